// File: doc/BRIEF.md
# SD Host Command Issue Engine

This block is the command half of an SD host controller, presented to software as a small word-addressed register set. Software loads a 32-bit argument, then writes the command word. The write that reaches the command word's upper byte starts the command. The engine serializes a 48-bit command frame onto the card's command line, one bit per card-clock strobe. It then waits for the card's reply and shifts in either a 48-bit or a 136-bit response. The stored response, the completion and error events, and the present-state inhibit flags are all available for software to read back.

Two present-state flags tell software when a new command may go out. One flag covers the command line itself. The other covers commands that occupy the data lines, either because they carry data or because the card signals busy after its response. A stop command is allowed through even while the data-line flag is set. Status bits are cleared by writing ones to them. Three self-clearing soft-reset bits abort the command path, release the data-line state, or return the whole block to its idle contents. The response CRC is not computed here: an external checker reports the result on a flag input. The data lines appear only as a single busy level.

Top module: `sdcmd_engine`

Register offsets (byte addresses, one 32-bit word each):

| Offset | Register |
|---|---|
| 0x00 | argument |
| 0x04 | command |
| 0x08, 0x0C, 0x10, 0x14 | response words 0 to 3 |
| 0x18 | present state |
| 0x1C | interrupt status |
| 0x20 | soft reset |

## Requirements
- R1: After reset, every register reads 0, `cmd_oe` is 0 and `cmd_out` is 1.
- R2: A command starts when the command word is written with `reg_wstrb[1]` set. The command word holds the index in [13:8], the data flag in bit 5, the index-check flag in bit 4, the CRC-check flag in bit 3 and the response type in [1:0]. The frame `{0, 1, index[5:0], argument[31:0], 7'h00, 1}` is then driven MSB first, one bit per `card_tick`, with `cmd_oe` high for all 48 bits.
- R3: Present-state bit 0 (command inhibit) is 1 from the start of a command until it completes or fails. Bit 1 (data inhibit) is set when a command starts that has the data flag or response type 3.
- R4: A command-word or argument write made while command inhibit is set is dropped. A start write is also dropped when data inhibit is set and the new command has the data flag or type 3, unless its index is 12.
- R5: Response type 2 (short) and type 3 (short with busy) capture 48 bits. Bits [39:8] of the captured frame go into response word 0, and words 1 to 3 keep their values.
- R6: Response type 1 (long) captures 136 bits. The 120-bit response store receives frame bits [127:8], so the top byte of word 3 reads 0.
- R7: Response type 0 sets the completion bit (interrupt bit 0) once the frame is sent and captures nothing.
- R8: If 64 card ticks pass without a start bit (a 0 on `cmd_in`), interrupt bit 16 is set, completion is not set and command inhibit is released. A start bit on the 64th tick is still accepted.
- R9: At the end of a response, three errors are checked. If the index check is on and the returned index differs from the sent one, bit 19 is set. If the CRC check is on and `resp_crc_ok` is 0, bit 17 is set. If the end bit is 0, bit 18 is set. Any of these errors suppresses completion. With a check flag off, its result is ignored.
- R10: For type 3, the data-end bit (interrupt bit 1) is set and data inhibit released only once `card_busy` is low after an error-free response.
- R11: Interrupt bits are cleared by writing 1s. Bit 15 reads as the OR of bits [31:16], and writing it has no effect.
- R12: Writing 1 to soft-reset bit 0 (all), bit 1 (command line) or bit 2 (data line) makes that bit read 1 for RST_CYCLES cycles and then 0. The command reset aborts the frame and clears command inhibit. The data reset clears data inhibit. The all reset does both and also clears every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Write byte address |
| reg_wdata | input | 32 | Write data |
| reg_wstrb | input | 4 | Byte enables for the write |
| reg_rd_addr | input | 6 | Read byte address |
| reg_rdata | output | 32 | Read data for `reg_rd_addr` |
| card_tick | input | 1 | One-cycle strobe per card clock |
| cmd_out | output | 1 | Command line value driven to the card |
| cmd_oe | output | 1 | Command line output enable |
| cmd_in | input | 1 | Command line value from the card |
| resp_crc_ok | input | 1 | External CRC check result for the response |
| card_busy | input | 1 | Card holds data line 0 busy |

## Verification
Several properties are checked by the assertions on every cycle:
- command inhibit stays set while the engine is off idle;
- the serialized bit holds between card ticks;
- a timeout or a data-end event appears only from the right waiting state;
- a command-line reset leaves the engine idle on the next cycle.

The bench scenarios are the only way to show the data-dependent results. These are frame contents, the response layout after CRC-byte stripping, the 64-tick timeout boundary, the blocking and stop-command exemption rules, and the write-one-to-clear behaviour with its summary bit.

// File: rtl/sdcmd_pkg.sv
// Package: shared encodings for the SD command issue engine.
// Holds the register offsets, the interrupt bit positions and the
// response-type and engine-state encodings used by all modules.
package sdcmd_pkg;

    localparam int FRAME_BITS = 48;
    localparam int LONG_BITS  = 136;

    localparam logic [5:0] OFF_ARG   = 6'h00;
    localparam logic [5:0] OFF_CMD   = 6'h04;
    localparam logic [5:0] OFF_RSP0  = 6'h08;
    localparam logic [5:0] OFF_RSP1  = 6'h0C;
    localparam logic [5:0] OFF_RSP2  = 6'h10;
    localparam logic [5:0] OFF_RSP3  = 6'h14;
    localparam logic [5:0] OFF_STATE = 6'h18;
    localparam logic [5:0] OFF_INT   = 6'h1C;
    localparam logic [5:0] OFF_RST   = 6'h20;

    localparam int INT_DONE   = 0;
    localparam int INT_DEND   = 1;
    localparam int INT_ERRSUM = 15;
    localparam int INT_TOUT   = 16;
    localparam int INT_CRC    = 17;
    localparam int INT_ENDB   = 18;
    localparam int INT_IDX    = 19;

    // bits of the interrupt word that hold real state
    localparam logic [31:0] INT_IMPL = 32'h000F_0003;

    typedef enum logic [1:0] {
        RESP_NONE  = 2'b00,
        RESP_LONG  = 2'b01,
        RESP_SHORT = 2'b10,
        RESP_BUSY  = 2'b11
    } resp_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_LOAD = 2'b01,
        ST_TX   = 2'b10,
        ST_RX   = 2'b11
    } eng_state_e;

endpackage

// File: rtl/sdcmd_tx.sv
// Module: command frame serializer.
// Loads a FRAME_W-bit frame on start and shifts it out MSB first, one
// bit per card tick. Pulses done for one cycle after the last bit.
// Assumes start is not raised while a frame is in flight.
module sdcmd_tx #(
    parameter int FRAME_W = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               abort,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    input  logic               tick,
    output logic               line_out,
    output logic               line_oe,
    output logic               done
);
    localparam int CNT_W = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;
    logic               busy;

    // shift register, bit counter and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            shreg <= '1;
            cnt   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                shreg <= frame;
                cnt   <= CNT_W'(FRAME_W);
                busy  <= 1'b1;
            end else if (busy && tick) begin
                shreg <= {shreg[FRAME_W-2:0], 1'b1};
                cnt   <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign line_out = busy ? shreg[FRAME_W-1] : 1'b1;
    assign line_oe  = busy;

    // a driven bit only changes on a card tick
    assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick && !start && !abort) |=> $stable(line_out));

    // done follows a shifting state
    assert_tx_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

endmodule

// File: rtl/sdcmd_rx.sv
// Module: response receiver.
// After start, hunts for a start bit for at most TIMEOUT_TICKS card ticks,
// then shifts in a short or long response MSB first. The start bit lands
// in the top bit of the selected length. Pulses done or timeout once.
module sdcmd_rx #(
    parameter int SHORT_W       = 48,
    parameter int LONG_W        = 136,
    parameter int TIMEOUT_TICKS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start,
    input  logic              long_sel,
    input  logic              tick,
    input  logic              line_in,
    output logic [LONG_W-1:0] data,
    output logic              done,
    output logic              timeout
);
    localparam int BIT_CW  = $clog2(LONG_W + 1);
    localparam int WAIT_CW = $clog2(TIMEOUT_TICKS + 1);

    logic               hunting;
    logic               receiving;
    logic [WAIT_CW-1:0] wcnt;
    logic [BIT_CW-1:0]  bcnt;
    logic [BIT_CW-1:0]  target;

    // start-bit hunt with tick timeout, then bit capture
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            hunting   <= 1'b0;
            receiving <= 1'b0;
            wcnt      <= '0;
            bcnt      <= '0;
            target    <= '0;
            data      <= '0;
            done      <= 1'b0;
            timeout   <= 1'b0;
        end else begin
            done    <= 1'b0;
            timeout <= 1'b0;
            if (start) begin
                hunting   <= 1'b1;
                receiving <= 1'b0;
                wcnt      <= '0;
                bcnt      <= '0;
                target    <= long_sel ? BIT_CW'(LONG_W) : BIT_CW'(SHORT_W);
                data      <= '0;
            end else if (hunting && tick) begin
                if (!line_in) begin
                    hunting   <= 1'b0;
                    receiving <= 1'b1;
                    bcnt      <= BIT_CW'(1);
                end else if (wcnt == WAIT_CW'(TIMEOUT_TICKS - 1)) begin
                    hunting <= 1'b0;
                    timeout <= 1'b1;
                end else begin
                    wcnt <= wcnt + 1'b1;
                end
            end else if (receiving && tick) begin
                data <= {data[LONG_W-2:0], line_in};
                bcnt <= bcnt + 1'b1;
                if (bcnt + 1'b1 == target) begin
                    receiving <= 1'b0;
                    done      <= 1'b1;
                end
            end
        end
    end

    // timeout is only reported out of the hunt phase
    assert_rx_tout_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> $past(hunting));

    // completion is only reported out of the capture phase
    assert_rx_done_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(receiving));

    // the two phases never overlap
    assert_rx_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hunting, receiving}));

endmodule

// File: rtl/sdcmd_rstseq.sv
// Module: self-clearing soft-reset sequencer.
// Each of N_RST request bits, once written, stays active for RST_CYCLES
// clock cycles and then clears itself. A write to a bit that is already
// active is ignored.
module sdcmd_rstseq #(
    parameter int N_RST      = 3,
    parameter int RST_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_RST-1:0] req,
    output logic [N_RST-1:0] active
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    for (genvar i = 0; i < N_RST; i++) begin : g_seq
        logic [CW-1:0] cnt;

        // per-bit hold counter
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                active[i] <= 1'b0;
                cnt       <= '0;
            end else if (req[i] && !active[i]) begin
                active[i] <= 1'b1;
                cnt       <= CW'(RST_CYCLES - 1);
            end else if (active[i]) begin
                if (cnt == '0) active[i] <= 1'b0;
                else           cnt <= cnt - 1'b1;
            end
        end

        assert_rst_arm_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (req[i] && !active[i]) |=> active[i]);
    end

endmodule

// File: rtl/sdcmd_engine.sv
// Module: SD host command issue engine (top).
// Register front end, command sequencing, response storage, status and
// inhibit tracking. Instantiates the frame serializer, the response
// receiver and the soft-reset sequencer. Assumes card_tick is a one-cycle
// strobe and that the response CRC is checked outside this block.
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 64,
    parameter int RST_CYCLES    = 4,
    parameter int STOP_INDEX    = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic [3:0]  reg_wstrb,
    input  logic [5:0]  reg_rd_addr,
    output logic [31:0] reg_rdata,
    input  logic        card_tick,
    output logic        cmd_out,
    output logic        cmd_oe,
    input  logic        cmd_in,
    input  logic        resp_crc_ok,
    input  logic        card_busy
);
    localparam int RSP_W = 120;

    eng_state_e    state;
    logic [31:0]   arg_q;
    logic [15:0]   cmd_q;
    logic [127:0]  rsp_q;
    logic [31:0]   sts_q;
    logic          cmd_inh;
    logic          data_inh;
    logic          busy_wait;

    logic [2:0]    rst_req;
    logic [2:0]    rst_act;
    logic          cmd_clr;
    logic          data_clr;

    logic [FRAME_BITS-1:0] frame;
    logic                  tx_start;
    logic                  tx_done;
    logic [LONG_BITS-1:0]  rx_data;
    logic                  rx_start;
    logic                  rx_done;
    logic                  rx_tout;

    // ---------------- write decode ----------------
    logic [15:0]  new_cmd;
    logic [5:0]   new_idx;
    resp_kind_e   new_kind;
    logic         new_uses_dat;
    logic         dat_block;
    logic         wr_allowed;
    logic         wr_cmd;
    logic         cmd_accept;
    logic         issue;
    logic [31:0]  byte_mask;
    logic [31:0]  clr_mask;
    logic [31:0]  set_mask;

    // byte-enable expansion for partial writes
    always_comb begin
        for (int b = 0; b < 4; b++) byte_mask[b*8 +: 8] = {8{reg_wstrb[b]}};
    end

    // command-write merge and issue gating
    always_comb begin
        new_cmd[7:0]  = reg_wstrb[0] ? reg_wdata[7:0]  : cmd_q[7:0];
        new_cmd[15:8] = reg_wstrb[1] ? reg_wdata[15:8] : cmd_q[15:8];
        new_idx       = new_cmd[13:8];
        new_kind      = resp_kind_e'(new_cmd[1:0]);
        new_uses_dat  = new_cmd[5] || (new_kind == RESP_BUSY);
        dat_block     = data_inh && new_uses_dat && (new_idx != 6'(STOP_INDEX));
        wr_allowed    = !cmd_inh && !(|rst_act);
        wr_cmd        = reg_wr && (reg_addr == OFF_CMD);
        cmd_accept    = wr_cmd && wr_allowed && !(reg_wstrb[1] && dat_block);
        issue         = cmd_accept && reg_wstrb[1];
    end

    assign rst_req  = (reg_wr && reg_addr == OFF_RST && reg_wstrb[0]) ? reg_wdata[2:0] : 3'b000;
    assign cmd_clr  = rst_act[0] | rst_act[1];
    assign data_clr = rst_act[0] | rst_act[2];

    // ---------------- submodules ----------------
    resp_kind_e cur_kind;
    assign cur_kind = resp_kind_e'(cmd_q[1:0]);
    assign frame    = {1'b0, 1'b1, cmd_q[13:8], arg_q, 7'h00, 1'b1};
    assign tx_start = (state == ST_LOAD);
    assign rx_start = (state == ST_TX) && tx_done && (cur_kind != RESP_NONE);

    sdcmd_tx #(.FRAME_W(FRAME_BITS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (cmd_clr),
        .start    (tx_start),
        .frame    (frame),
        .tick     (card_tick),
        .line_out (cmd_out),
        .line_oe  (cmd_oe),
        .done     (tx_done)
    );

    sdcmd_rx #(
        .SHORT_W       (FRAME_BITS),
        .LONG_W        (LONG_BITS),
        .TIMEOUT_TICKS (TIMEOUT_TICKS)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (cmd_clr),
        .start    (rx_start),
        .long_sel (cur_kind == RESP_LONG),
        .tick     (card_tick),
        .line_in  (cmd_in),
        .data     (rx_data),
        .done     (rx_done),
        .timeout  (rx_tout)
    );

    sdcmd_rstseq #(.N_RST(3), .RST_CYCLES(RST_CYCLES)) u_rst (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (rst_req),
        .active (rst_act)
    );

    // ---------------- response checks ----------------
    logic [5:0] got_idx;
    logic       idx_err;
    logic       crc_err;
    logic       end_err;
    logic       any_err;
    logic       rsp_end;
    logic       unused_rx;

    // error evaluation at the last response bit
    always_comb begin
        got_idx = (cur_kind == RESP_LONG) ? rx_data[133:128] : rx_data[45:40];
        idx_err = cmd_q[4] && (got_idx != cmd_q[13:8]);
        crc_err = cmd_q[3] && !resp_crc_ok;
        end_err = !rx_data[0];
        any_err = idx_err || crc_err || end_err;
        rsp_end = (state == ST_RX) && rx_done;
    end
    assign unused_rx = ^rx_data[135:134];

    // ---------------- interrupt events ----------------
    logic set_done;
    logic set_dend;
    logic set_tout;

    // event sources and the write-one-to-clear mask
    always_comb begin
        set_done = ((state == ST_TX) && tx_done && (cur_kind == RESP_NONE)) ||
                   (rsp_end && !any_err);
        set_dend = busy_wait && !card_busy && !data_clr;
        set_tout = (state == ST_RX) && rx_tout;
        set_mask = '0;
        set_mask[INT_DONE] = set_done;
        set_mask[INT_DEND] = set_dend;
        set_mask[INT_TOUT] = set_tout;
        set_mask[INT_CRC]  = rsp_end && crc_err;
        set_mask[INT_ENDB] = rsp_end && end_err;
        set_mask[INT_IDX]  = rsp_end && idx_err;
        clr_mask = (reg_wr && reg_addr == OFF_INT) ? (reg_wdata & byte_mask & INT_IMPL) : '0;
    end

    // ---------------- state ----------------
    // command sequencing and command inhibit
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_clr) begin
            state   <= ST_IDLE;
            cmd_inh <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (issue) begin
                    state   <= ST_LOAD;
                    cmd_inh <= 1'b1;
                end
                ST_LOAD: state <= ST_TX;
                ST_TX: if (tx_done) begin
                    if (cur_kind == RESP_NONE) begin
                        state   <= ST_IDLE;
                        cmd_inh <= 1'b0;
                    end else begin
                        state <= ST_RX;
                    end
                end
                ST_RX: if (rx_done || rx_tout) begin
                    state   <= ST_IDLE;
                    cmd_inh <= 1'b0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // data inhibit and busy-release tracking
    always_ff @(posedge clk) begin
        if (!rst_n || data_clr) begin
            data_inh  <= 1'b0;
            busy_wait <= 1'b0;
        end else begin
            if (set_dend) begin
                busy_wait <= 1'b0;
                data_inh  <= 1'b0;
            end
            if (issue && new_uses_dat) data_inh <= 1'b1;
            if (rsp_end && !any_err && cur_kind == RESP_BUSY) busy_wait <= 1'b1;
        end
    end

    // argument and command word registers
    always_ff @(posedge clk) begin
        if (!rst_n || rst_act[0]) begin
            arg_q <= '0;
            cmd_q <= '0;
        end else begin
            if (reg_wr && reg_addr == OFF_ARG && wr_allowed)
                arg_q <= (reg_wdata & byte_mask) | (arg_q & ~byte_mask);
            if (cmd_accept) cmd_q <= new_cmd;
        end
    end

    // response store with CRC byte stripped for long replies
    always_ff @(posedge clk) begin
        if (!rst_n || rst_act[0]) begin
            rsp_q <= '0;
        end else if (rsp_end) begin
            if (cur_kind == RESP_LONG) begin
                rsp_q[RSP_W-1:0] <= rx_data[127:8];
                rsp_q[127:RSP_W] <= '0;
            end else begin
                rsp_q[31:0] <= rx_data[39:8];
            end
        end
    end

    // interrupt status, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n || rst_act[0]) sts_q <= '0;
        else                      sts_q <= (sts_q & ~clr_mask) | set_mask;
    end

    // ---------------- read mux ----------------
    // register read-back
    always_comb begin
        case (reg_rd_addr)
            OFF_ARG:   reg_rdata = arg_q;
            OFF_CMD:   reg_rdata = {16'h0, cmd_q};
            OFF_RSP0:  reg_rdata = rsp_q[31:0];
            OFF_RSP1:  reg_rdata = rsp_q[63:32];
            OFF_RSP2:  reg_rdata = rsp_q[95:64];
            OFF_RSP3:  reg_rdata = rsp_q[127:96];
            OFF_STATE: reg_rdata = {30'h0, data_inh, cmd_inh};
            OFF_INT: begin
                reg_rdata = sts_q;
                reg_rdata[INT_ERRSUM] = |sts_q[31:16];
            end
            OFF_RST:   reg_rdata = {29'h0, rst_act};
            default:   reg_rdata = {31'h0, unused_rx & 1'b0};
        endcase
    end

    // ---------------- assertions ----------------
    assert_inh_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> cmd_inh);

    assert_dinh_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_wait |-> data_inh);

    assert_issue_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_inh) |-> $past(reg_wr));

    assert_tout_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[INT_TOUT]) |-> !cmd_inh);

    assert_err_no_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_end && any_err) |=> !$rose(sts_q[INT_DONE]));

    assert_dend_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[INT_DEND]) |-> $past(busy_wait));

    assert_cmdrst_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_clr |=> (state == ST_IDLE && !cmd_inh && !cmd_oe));

endmodule

// File: tb/sdcmd_engine_test.sv
module sdcmd_engine_test;
    import sdcmd_pkg::*;

    localparam int RSTC = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [5:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [3:0]  reg_wstrb;
    logic [5:0]  reg_rd_addr;
    logic [31:0] reg_rdata;
    logic        card_tick;
    logic        cmd_out;
    logic        cmd_oe;
    logic        cmd_in;
    logic        resp_crc_ok;
    logic        card_busy;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    sdcmd_engine #(.TIMEOUT_TICKS(64), .RST_CYCLES(RSTC), .STOP_INDEX(12)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wstrb(reg_wstrb), .reg_rd_addr(reg_rd_addr),
        .reg_rdata(reg_rdata), .card_tick(card_tick), .cmd_out(cmd_out),
        .cmd_oe(cmd_oe), .cmd_in(cmd_in), .resp_crc_ok(resp_crc_ok),
        .card_busy(card_busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_wstrb = s;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_rd_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic tick(input logic b, output logic s);
        @(negedge clk);
        cmd_in = b; card_tick = 1'b1; s = cmd_out;
        @(negedge clk);
        card_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic grab(output logic [47:0] f);
        logic s;
        f = '0;
        for (int i = 0; i < 48; i++) begin
            tick(1'b1, s);
            f = {f[46:0], s};
        end
    endtask

    task automatic respond(input int gap, input logic [135:0] bits, input int n);
        logic s;
        for (int i = 0; i < gap; i++) tick(1'b1, s);
        for (int i = n - 1; i >= 0; i--) tick(bits[i], s);
        cmd_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [47:0] exp_frame(input logic [5:0] idx, input logic [31:0] arg);
        return {2'b01, idx, arg, 7'h00, 1'b1};
    endfunction

    function automatic logic [135:0] short_rsp(input logic [5:0] idx, input logic [31:0] st, input logic endb);
        return {88'h0, 2'b00, idx, st, 7'h35, endb};
    endfunction

    function automatic logic [135:0] long_rsp(input logic [126:0] pl);
        return {2'b00, 6'h3F, pl, 1'b1};
    endfunction

    function automatic logic [31:0] mk_cmd(input logic [5:0] idx, input logic dat,
                                           input logic ichk, input logic cchk, input logic [1:0] k);
        return {16'h0, 2'b00, idx, 2'b00, dat, ichk, cchk, 1'b0, k};
    endfunction

    logic [127:0] ersp;
    logic [47:0]  fr;
    logic [135:0] rb;
    logic [31:0]  arg;
    logic [31:0]  stv;
    logic [5:0]   idx;
    logic [126:0] pl;
    int           kind;
    int           seed;

    // watchdog
    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; reg_wstrb = '0;
        reg_rd_addr = '0; card_tick = 1'b0; cmd_in = 1'b1; resp_crc_ok = 1'b1;
        card_busy = 1'b0; ersp = '0;
        seed = 13;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 cmd_oe", {31'h0, cmd_oe}, 32'h0);
        chk("R1 cmd_out", {31'h0, cmd_out}, 32'h1);
        for (int a = 0; a <= 8; a++) rd_chk("R1 reg", 6'(a * 4), 32'h0);

        // random commands: none / long / short
        for (int it = 0; it < 10; it++) begin
            kind = $urandom % 3;
            idx  = 6'($urandom);
            arg  = $urandom;
            wr(OFF_ARG, arg, 4'hF);
            if (kind == 0)      wr(OFF_CMD, mk_cmd(idx, 0, 0, 0, 2'b00), 4'h3);
            else if (kind == 1) wr(OFF_CMD, mk_cmd(idx, 0, 0, 1, 2'b01), 4'h3);
            else                wr(OFF_CMD, mk_cmd(idx, 0, 1, 1, 2'b10), 4'h3);
            rd_chk("R3 cmd inhibit set", OFF_STATE, 32'h1);
            grab(fr);
            chk("R2 frame hi", fr[47:16], exp_frame(idx, arg) >> 16);
            chk("R2 frame lo", {16'h0, fr[15:0]}, {16'h0, exp_frame(idx, arg) & 48'hFFFF});
            if (kind == 0) begin
                repeat (4) @(negedge clk);
                rd_chk("R7 done", OFF_INT, 32'h1);
            end else if (kind == 1) begin
                pl = {$urandom, $urandom, $urandom, $urandom};
                rb = long_rsp(pl);
                respond($urandom % 20, rb, 136);
                ersp = {8'h0, rb[127:8]};
                rd_chk("R6 done", OFF_INT, 32'h1);
            end else begin
                stv = $urandom;
                respond($urandom % 20, short_rsp(idx, stv, 1'b1), 48);
                ersp[31:0] = stv;
                rd_chk("R5 done", OFF_INT, 32'h1);
            end
            for (int w = 0; w < 4; w++) rd_chk("R5 R6 response word", 6'(8 + 4 * w), ersp[32 * w +: 32]);
            rd_chk("R3 cmd inhibit clear", OFF_STATE, 32'h0);
            wr(OFF_INT, 32'hFFFF_FFFF, 4'hF);
            rd_chk("R11 w1c clear", OFF_INT, 32'h0);
        end

        // R8: timeout after 64 idle ticks
        wr(OFF_CMD, mk_cmd(6'd3, 0, 0, 0, 2'b10), 4'h3);
        grab(fr);
        respond(64, 136'h0, 0);
        rd_chk("R8 timeout status", OFF_INT, 32'h0001_8000);
        rd_chk("R8 inhibit released", OFF_STATE, 32'h0);
        wr(OFF_INT, 32'hFFFF_FFFF, 4'hF);

        // R8: start bit on the 64th tick still accepted
        wr(OFF_CMD, mk_cmd(6'd3, 0, 0, 0, 2'b10), 4'h3);
        grab(fr);
        respond(63, short_rsp(6'd3, 32'hA5A5_0001, 1'b1), 48);
        rd_chk("R8 boundary ok", OFF_INT, 32'h1);
        rd_chk("R5 boundary rsp", OFF_RSP0, 32'hA5A5_0001);
        wr(OFF_INT, 32'hFFFF_FFFF, 4'hF);

        // R9: index mismatch
        wr(OFF_CMD, mk_cmd(6'd8, 0, 1, 0, 2'b10), 4'h3);
        grab(fr);
        respond(2, short_rsp(6'd9, 32'h0000_0900, 1'b1), 48);
        rd_chk("R9 index error", OFF_INT, 32'h0008_8000);
        // R11: writing the summary bit alone does nothing
        wr(OFF_INT, 32'h0000_8000, 4'hF);
        rd_chk("R11 summary write ignored", OFF_INT, 32'h0008_8000);
        wr(OFF_INT, 32'h0008_0000, 4'hF);
        rd_chk("R11 summary follows", OFF_INT, 32'h0);

        // R9: CRC failure with check on
        resp_crc_ok = 1'b0;
        wr(OFF_CMD, mk_cmd(6'd8, 0, 0, 1, 2'b10), 4'h3);
        grab(fr);
        respond(2, short_rsp(6'd8, 32'h1, 1'b1), 48);
        rd_chk("R9 crc error", OFF_INT, 32'h0002_8000);
        wr(OFF_INT, 32'hFFFF_FFFF, 4'hF);
        // R9: CRC failure ignored with check off, index mismatch ignored too
        wr(OFF_CMD, mk_cmd(6'd8, 0, 0, 0, 2'b10), 4'h3);
        grab(fr);
        respond(2, short_rsp(6'd1, 32'h2, 1'b1), 48);
        rd_chk("R9 checks off", OFF_INT, 32'h1);
        wr(OFF_INT, 32'hFFFF_FFFF, 4'hF);
        resp_crc_ok = 1'b1;

        // R9: end bit zero
        wr(OFF_CMD, mk_cmd(6'd8, 0, 0, 0, 2'b10), 4'h3);
        grab(fr);
        respond(2, short_rsp(6'd8, 32'h3, 1'b0), 48);
        rd_chk("R9 end bit error", OFF_INT, 32'h0004_8000);
        wr(OFF_INT, 32'hFFFF_FFFF, 4'hF);

        // R10: busy response
        card_busy = 1'b1;
        wr(OFF_CMD, mk_cmd(6'd7, 0, 0, 0, 2'b11), 4'h3);
        rd_chk("R3 both inhibits", OFF_STATE, 32'h3);
        grab(fr);
        respond(1, short_rsp(6'd7, 32'h7, 1'b1), 48);
        rd_chk("R10 no data end while busy", OFF_INT, 32'h1);
        rd_chk("R10 data inhibit held", OFF_STATE, 32'h2);
        wr(OFF_INT, 32'hFFFF_FFFF, 4'hF);

        // R4: busy command blocked by data inhibit
        wr(OFF_CMD, mk_cmd(6'd5, 0, 0, 0, 2'b11), 4'h3);
        repeat (3) @(negedge clk);
        chk("R4 blocked no drive", {31'h0, cmd_oe}, 32'h0);
        rd_chk("R4 blocked state", OFF_STATE, 32'h2);
        rd_chk("R4 cmd word kept", OFF_CMD, mk_cmd(6'd7, 0, 0, 0, 2'b11));
        wr(OFF_CMD, mk_cmd(6'd6, 1, 0, 0, 2'b10), 4'h3);
        rd_chk("R4 data cmd blocked", OFF_STATE, 32'h2);
        // R4: stop command allowed through
        wr(OFF_CMD, mk_cmd(6'd12, 0, 1, 0, 2'b11), 4'h3);
        rd_chk("R4 stop accepted", OFF_STATE, 32'h3);
        grab(fr);
        chk("R4 stop frame", {26'h0, fr[45:40]}, 32'd12);
        respond(1, short_rsp(6'd12, 32'hC, 1'b1), 48);
        rd_chk("R10 still busy", OFF_STATE, 32'h2);
        card_busy = 1'b0;
        repeat (3) @(negedge clk);
        rd_chk("R10 data end", OFF_INT, 32'h3);
        rd_chk("R10 inhibit released", OFF_STATE, 32'h0);
        wr(OFF_INT, 32'hFFFF_FFFF, 4'hF);

        // R4: write during command inhibit dropped
        wr(OFF_ARG, 32'h1234_5678, 4'hF);
        wr(OFF_CMD, mk_cmd(6'd9, 0, 0, 0, 2'b00), 4'h3);
        wr(OFF_CMD, mk_cmd(6'd10, 0, 0, 0, 2'b00), 4'h3);
        wr(OFF_ARG, 32'hDEAD_BEEF, 4'hF);
        grab(fr);
        chk("R4 frame unchanged hi", fr[47:16], exp_frame(6'd9, 32'h1234_5678) >> 16);
        repeat (4) @(negedge clk);
        rd_chk("R4 arg kept", OFF_ARG, 32'h1234_5678);
        wr(OFF_INT, 32'hFFFF_FFFF, 4'hF);

        // R12: command-line reset mid-frame
        wr(OFF_CMD, mk_cmd(6'd2, 0, 0, 0, 2'b10), 4'h3);
        for (int i = 0; i < 10; i++) begin
            logic s;
            tick(1'b1, s);
        end
        wr(OFF_RST, 32'h2, 4'h1);
        rd_chk("R12 cmd reset reads 1", OFF_RST, 32'h2);
        repeat (RSTC + 2) @(negedge clk);
        rd_chk("R12 cmd reset self clears", OFF_RST, 32'h0);
        rd_chk("R12 cmd inhibit cleared", OFF_STATE, 32'h0);
        chk("R12 line released", {31'h0, cmd_oe}, 32'h0);

        // R12: data-line reset
        wr(OFF_CMD, mk_cmd(6'd17, 1, 0, 0, 2'b00), 4'h3);
        grab(fr);
        repeat (4) @(negedge clk);
        rd_chk("R3 data flag inhibit", OFF_STATE, 32'h2);
        wr(OFF_RST, 32'h4, 4'h1);
        repeat (RSTC + 2) @(negedge clk);
        rd_chk("R12 data inhibit cleared", OFF_STATE, 32'h0);

        // R12: full reset clears registers
        rd_chk("R12 status before", OFF_INT, 32'h1);
        wr(OFF_RST, 32'h1, 4'h1);
        rd_chk("R12 all reads 1", OFF_RST, 32'h1);
        repeat (RSTC + 2) @(negedge clk);
        rd_chk("R12 status cleared", OFF_INT, 32'h0);
        rd_chk("R12 arg cleared", OFF_ARG, 32'h0);
        rd_chk("R12 response cleared", OFF_RSP0, 32'h0);
        rd_chk("R12 cmd cleared", OFF_CMD, 32'h0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule